// File: doc/BRIEF.md
# Peripheral Reset Line Controller

This block holds the reset state of a bank of peripheral reset lines and lets software change it through a small 32-bit register bus. The bus has a byte address, a write enable, write data and combinational read data. Each line is active high. A line stays asserted from the write that raises it until a later write lowers it. The block enforces no minimum pulse width, so software decides how long a peripheral is held in reset.

A build-time parameter chooses one of two register layouts:

- **Direct layout.** Each 32-line group has a single read/write register. Software updates it with a read-modify-write sequence.
- **Set/clear layout.** Each group has a pair of registers. Ones written to the set register raise lines, and ones written to the clear register lower them. Other lines in the group are left untouched, so no read-modify-write is needed.

In both layouts, a write to offset 0 with bit 31 set also produces a one-cycle whole-system reset request.

Top module: `periph_reset_ctrl`

## Requirements
- R1: After power-on reset, all 64 peripheral reset lines are low and the system reset request is low.
- R2: Line index i belongs to group i/32 and sits at bit position i mod 32 of that group's register. The same position is used for the output vector `periph_rst[i]` and for read data.
- R3: Direct layout: group g has one register at byte offset 4*g. A write loads all 32 lines of the group from the data: a 1 asserts the line and a 0 releases it. The new state appears on the outputs after the clock edge that takes the write.
- R4: Set/clear layout: the set register of group g is at byte offset 8*g. Each 1 in the written data asserts the matching line, and each 0 leaves the matching line unchanged.
- R5: Set/clear layout: the clear register of group g is at byte offset 8*g+4. Each 1 in the written data releases the matching line, and each 0 leaves the matching line unchanged.
- R6: Reading a mapped offset returns the current state of that group's 32 lines. In the set/clear layout, the set offset and the clear offset both return that state.
- R7: Unmapped offsets are ignored on write and read as zero. Unmapped offsets are those not word aligned, those past the last group, and, in the direct layout, 8 and above.
- R8: A write to byte offset 0 with data bit 31 set drives `sys_rst_req` high for exactly one cycle, starting after the edge that takes the write. The same write also updates group 0 as its layout defines.
- R9: With `wr_en` low, no line changes, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| periph_rst | output | 64 | Active-high peripheral reset lines |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The following are checked on every clock cycle:

- the request is a single-cycle pulse, and only a qualifying write causes it;
- lines hold while no write occurs;
- misaligned reads return zero;
- offset 0 reads back group 0;
- the effect of a write to group 0's registers in the chosen layout.

The bench covers what needs a model of the whole bank. It instantiates both layouts on one shared bus. It sweeps every offset in a small window with several data patterns, and after each write it reads back every offset. It also walks a single asserted line across all 64 indices. These scenarios show mapping, isolation between groups and the ignoring of unmapped writes.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   typedef enum logic [0:0] {
      LAYOUT_DIRECT   = 1'b0,
      LAYOUT_SETCLEAR = 1'b1
   } layout_e;

   // Byte stride between consecutive groups for a layout.
   function automatic int group_stride(layout_e lay);
      return (lay == LAYOUT_DIRECT) ? 4 : 8;
   endfunction
endpackage

// File: rtl/rstc_addr_decode.sv
module rstc_addr_decode #(
   parameter int                N_GROUPS = 2,
   parameter int                ADDR_W   = 8,
   parameter rstc_pkg::layout_e LAYOUT   = rstc_pkg::LAYOUT_DIRECT
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr_en,
   output logic [N_GROUPS-1:0] rd_hit,
   output logic [N_GROUPS-1:0] wr_load,
   output logic [N_GROUPS-1:0] wr_set,
   output logic [N_GROUPS-1:0] wr_clr,
   output logic                sys_hit
);
   localparam int STRIDE = rstc_pkg::group_stride(LAYOUT);

   assign sys_hit = wr_en && (addr == '0);

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      if (LAYOUT == rstc_pkg::LAYOUT_DIRECT) begin : g_dir
         logic hit;
         assign hit        = (addr == ADDR_W'(g * STRIDE));
         assign rd_hit[g]  = hit;
         assign wr_load[g] = wr_en && hit;
         assign wr_set[g]  = 1'b0;
         assign wr_clr[g]  = 1'b0;
      end else begin : g_sc
         logic set_hit, clr_hit;
         assign set_hit    = (addr == ADDR_W'(g * STRIDE));
         assign clr_hit    = (addr == ADDR_W'(g * STRIDE + 4));
         assign rd_hit[g]  = set_hit || clr_hit;
         assign wr_load[g] = 1'b0;
         assign wr_set[g]  = wr_en && set_hit;
         assign wr_clr[g]  = wr_en && clr_hit;
      end
   end
endmodule

// File: rtl/rstc_group.sv
module rstc_group #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              set,
   input  logic              clr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] state
);
   logic [DATA_W-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= '0;
      end else if (load) begin
         state_q <= wdata;
      end else if (set) begin
         state_q <= state_q | wdata;
      end else if (clr) begin
         state_q <= state_q & ~wdata;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/rstc_sys_pulse.sv
module rstc_sys_pulse #(
   parameter int DATA_W  = 32,
   parameter int SYS_BIT = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] wdata,
   output logic              pulse
);
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= 1'b0;
      else        pulse_q <= hit && wdata[SYS_BIT];
   end

   assign pulse = pulse_q;
endmodule

// File: rtl/periph_reset_ctrl.sv
module periph_reset_ctrl #(
   parameter int                N_LINES = 64,
   parameter int                DATA_W  = 32,
   parameter int                ADDR_W  = 8,
   parameter int                SYS_BIT = 31,
   parameter rstc_pkg::layout_e LAYOUT  = rstc_pkg::LAYOUT_DIRECT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic [N_LINES-1:0] periph_rst,
   output logic               sys_rst_req
);
   localparam int N_GROUPS = N_LINES / DATA_W;
   localparam int SPAN     = N_GROUPS * rstc_pkg::group_stride(LAYOUT);

   if (N_LINES % DATA_W != 0) begin : g_bad_lines
      $error("N_LINES must be a multiple of DATA_W");
   end
   if (SYS_BIT >= DATA_W) begin : g_bad_sys
      $error("SYS_BIT must lie inside the data word");
   end
   if ((1 << ADDR_W) < SPAN) begin : g_bad_addr
      $error("ADDR_W too narrow for the register span");
   end

   logic [N_GROUPS-1:0] rd_hit, wr_load, wr_set, wr_clr;
   logic                sys_hit;
   logic [DATA_W-1:0]   grp_state [N_GROUPS];

   rstc_addr_decode #(
      .N_GROUPS(N_GROUPS), .ADDR_W(ADDR_W), .LAYOUT(LAYOUT)
   ) u_dec (
      .addr(addr), .wr_en(wr_en), .rd_hit(rd_hit), .wr_load(wr_load),
      .wr_set(wr_set), .wr_clr(wr_clr), .sys_hit(sys_hit)
   );

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_bank
      rstc_group #(.DATA_W(DATA_W)) u_grp (
         .clk(clk), .rst_n(rst_n), .load(wr_load[g]), .set(wr_set[g]),
         .clr(wr_clr[g]), .wdata(wr_data), .state(grp_state[g])
      );
      assign periph_rst[g*DATA_W +: DATA_W] = grp_state[g];
   end

   rstc_sys_pulse #(.DATA_W(DATA_W), .SYS_BIT(SYS_BIT)) u_sys (
      .clk(clk), .rst_n(rst_n), .hit(sys_hit), .wdata(wr_data),
      .pulse(sys_rst_req)
   );

   always_comb begin
      rd_data = '0;
      for (int g = 0; g < N_GROUPS; g++) begin
         if (rd_hit[g]) rd_data = rd_data | grp_state[g];
      end
   end
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
   parameter int                N_LINES = 64,
   parameter int                DATA_W  = 32,
   parameter int                ADDR_W  = 8,
   parameter int                SYS_BIT = 31,
   parameter rstc_pkg::layout_e LAYOUT  = rstc_pkg::LAYOUT_DIRECT
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  addr,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  rd_data,
   input logic [N_LINES-1:0] periph_rst,
   input logic               sys_rst_req
);
   // R1
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (periph_rst == '0 && !sys_rst_req));

   // R8
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |=> !sys_rst_req);
   a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == '0 && wr_data[SYS_BIT]) |=> sys_rst_req);
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == '0 && wr_data[SYS_BIT]) |=> !sys_rst_req);

   // R9
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(periph_rst));

   // R7
   a_r7_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[1:0] != 2'b00) |-> (rd_data == '0));

   // R6
   a_r6_read_group0: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == '0) |-> (rd_data == periph_rst[DATA_W-1:0]));

   if (LAYOUT == rstc_pkg::LAYOUT_DIRECT) begin : g_dir
      // R3
      a_r3_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == '0) |=> (periph_rst[DATA_W-1:0] == $past(wr_data)));
   end else begin : g_sc
      // R4
      a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == '0) |=>
            ((periph_rst[DATA_W-1:0] & $past(wr_data)) == $past(wr_data)));
      // R5
      a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(4)) |=>
            ((periph_rst[DATA_W-1:0] & $past(wr_data)) == '0));
   end
endmodule

bind periph_reset_ctrl rstc_checker #(
   .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .SYS_BIT(SYS_BIT), .LAYOUT(LAYOUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .periph_rst(periph_rst), .sys_rst_req(sys_rst_req)
);

// File: tb/tb_periph_reset_ctrl.sv
module tb_periph_reset_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_dir, rd_sc;
   logic [63:0] rst_dir, rst_sc;
   logic        sys_dir, sys_sc;

   int checks = 0;
   int errors = 0;
   logic [63:0] m_dir = '0;
   logic [63:0] m_sc  = '0;

   always #10 clk = ~clk;

   periph_reset_ctrl #(.LAYOUT(rstc_pkg::LAYOUT_DIRECT)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_dir), .periph_rst(rst_dir), .sys_rst_req(sys_dir)
   );

   periph_reset_ctrl #(.LAYOUT(rstc_pkg::LAYOUT_SETCLEAR)) dut_sc (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_sc), .periph_rst(rst_sc), .sys_rst_req(sys_sc)
   );

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit dir_mapped(input logic [7:0] o);
      return (o[1:0] == 2'b00) && (o < 8'd8);
   endfunction

   function automatic bit sc_mapped(input logic [7:0] o);
      return (o[1:0] == 2'b00) && (o < 8'd16);
   endfunction

   function automatic logic [31:0] exp_rd_dir(input logic [7:0] o);
      if (!dir_mapped(o)) return '0;
      return m_dir[32*int'(o >> 2) +: 32];
   endfunction

   function automatic logic [31:0] exp_rd_sc(input logic [7:0] o);
      if (!sc_mapped(o)) return '0;
      return m_sc[32*int'(o >> 3) +: 32];
   endfunction

   task automatic do_write(input logic [7:0] o, input logic [31:0] d);
      logic  exp_sys;
      string tag_d, tag_s;
      @(negedge clk);
      addr = o; wr_data = d; wr_en = 1'b1;
      exp_sys = (o == 8'd0) && d[31];
      if (dir_mapped(o)) begin
         m_dir[32*int'(o >> 2) +: 32] = d;
         tag_d = "R3";
      end else tag_d = "R7";
      if (sc_mapped(o)) begin
         if (o[2] == 1'b0) begin
            m_sc[32*int'(o >> 3) +: 32] = m_sc[32*int'(o >> 3) +: 32] | d;
            tag_s = "R4";
         end else begin
            m_sc[32*int'(o >> 3) +: 32] = m_sc[32*int'(o >> 3) +: 32] & ~d;
            tag_s = "R5";
         end
      end else tag_s = "R7";
      @(negedge clk);
      wr_en = 1'b0;
      check(tag_d, rst_dir, m_dir);
      check(tag_s, rst_sc, m_sc);
      check("R8 pulse high direct", {63'd0, sys_dir}, {63'd0, exp_sys});
      check("R8 pulse high setclr", {63'd0, sys_sc}, {63'd0, exp_sys});
      @(negedge clk);
      check("R8 pulse ends direct", {63'd0, sys_dir}, 64'd0);
      check("R8 pulse ends setclr", {63'd0, sys_sc}, 64'd0);
   endtask

   task automatic read_sweep();
      for (int o = 0; o < 20; o++) begin
         @(negedge clk);
         addr = 8'(o);
         #2;
         check(dir_mapped(8'(o)) ? "R6 direct" : "R7 direct",
               {32'd0, rd_dir}, {32'd0, exp_rd_dir(8'(o))});
         check(sc_mapped(8'(o)) ? "R6 setclr" : "R7 setclr",
               {32'd0, rd_sc}, {32'd0, exp_rd_sc(8'(o))});
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during and right after reset
      check("R1 lines direct", rst_dir, 64'd0);
      check("R1 lines setclr", rst_sc, 64'd0);
      check("R1 sysreq", {62'd0, sys_dir, sys_sc}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", rst_dir | rst_sc, 64'd0);
      read_sweep();

      // R2: walking single line over all 64 indices
      for (int i = 0; i < 64; i++) begin
         do_write(8'(4 * (i / 32)), 32'd1 << (i % 32));
         check("R2 direct index", rst_dir, (64'd1 << i) | m_dir);
         do_write(8'(8 * (i / 32)), 32'd1 << (i % 32));
         check("R2 setclr index", rst_sc, 64'd1 << i);
         do_write(8'(8 * (i / 32) + 4), 32'd1 << (i % 32));
         check("R2 setclr release", rst_sc, 64'd0);
         do_write(8'(4 * (i / 32)), 32'd0);
      end

      // Offset x pattern sweep (R3 R4 R5 R6 R7 R8)
      for (int p = 0; p < 6; p++) begin
         logic [31:0] d;
         d = (32'hA5C3_0F96 ^ (32'h1357_9BDF * 32'(p))) ^ (32'(p) << 31);
         for (int o = 0; o < 20; o++) begin
            do_write(8'(o), d ^ 32'(o * 32'h0101_0101));
         end
         do_write(8'hFC, 32'hFFFF_FFFF);
         do_write(8'h81, 32'hFFFF_FFFF);
         read_sweep();
      end

      // R8: explicit system request with and without bit 31
      do_write(8'd0, 32'h8000_0000);
      do_write(8'd0, 32'h7FFF_FFFF);
      do_write(8'd4, 32'h8000_0000);

      // R9: bus activity without write enable changes nothing
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         addr = 8'(4 * k); wr_data = ~m_dir[31:0];
      end
      @(negedge clk);
      check("R9 hold direct", rst_dir, m_dir);
      check("R9 hold setclr", rst_sc, m_sc);
      read_sweep();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule